// File: doc/BRIEF.md
# Approximate Byte-Pattern Matcher with Swap Tolerance

This block watches a byte stream, one byte per clock, for a fixed pattern that may appear with a bounded number of edits. An edit is one extra byte, one missing pattern byte, one wrong byte, or two neighbouring pattern bytes arriving in swapped order. Each of these costs exactly one. Any pattern position can accept either of two byte values, for example an upper-case letter and its lower-case form, or a letter and a digit that looks like it. The pattern, its alternate bytes and the edit budget are fixed when the block is elaborated.

Internally the block is a nondeterministic automaton with one flip-flop per state. The states form one row per error count. Extra one-byte states on the rows below the last make a swap of two bytes cost a single edit. A skipped pattern byte is folded into the next-state logic, so it costs no clock cycle. The input to every state register is an OR of at most five terms. The match flag and the error count come straight from the registered final states. A match can start anywhere in the stream. The outputs appear in the cycle after the byte that completes the match.

Top module: `apm_matcher`

## Requirements
- R1: When the bytes of every pattern position arrive in order, `match_o` is 1 and `err_o` is 0 in the cycle after the last byte is accepted. Bytes are compared on all 8 bits. The default pattern is "ABCD" with alternates "AbCd".
- R2: A position matches a byte equal to either its main byte or its alternate byte. By default, position 2 accepts "B" or "b" and position 4 accepts "D" or "d". Positions 1 and 3 accept only "A" and "C".
- R3: A wrong byte in place of one pattern position costs one edit.
- R4: An extra byte between two pattern positions costs one edit. Bytes that arrive after the last position never extend a match.
- R5: A missing pattern byte, including the first one, costs one edit and adds no clock cycle.
- R6: Two neighbouring pattern bytes that arrive swapped cost one edit, not two.
- R7: `err_o` reports the smallest edit count of any alignment that ends at the latest accepted byte. When that count exceeds MAX_ERR, `match_o` is 0. Whenever `match_o` is 0, `err_o` is 0.
- R8: While `din_valid` is 0, `din` is ignored and `match_o` and `err_o` hold their values.
- R9: A synchronous `rst` clears `match_o` and `err_o` to 0. It also discards all earlier bytes, so no later match can use them.
- R10: A match may begin at any byte of the stream. The result for a byte is visible in the cycle after that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_valid | input | 1 | The byte on `din` is consumed at this edge |
| din | input | 8 | Stream byte |
| match_o | output | 1 | A final state is active |
| err_o | output | $clog2(MAX_ERR+1) | Lowest error count among active final states |

## Verification
The bench builds the block with its defaults: a four-position pattern "ABCD" with alternates "AbCd" and an edit budget of two. Four positions leave room for a swap at the start, in the middle and at the end. A budget of two lets two-edit matches appear while three-edit strings still fail. Expected values come from an integer edit-distance recurrence over substrings that end at each byte. That recurrence shares nothing with the state rows. It is compared against the block on every cycle, including idle and reset cycles.

// File: rtl/apm_pkg.sv
package apm_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/apm_class_dec.sv
// Decodes one pattern position: matches the main byte or its alternate.
module apm_class_dec
    import apm_pkg::*;
#(
    parameter byte_t MAIN = 8'h41,
    parameter byte_t ALT  = 8'h41
) (
    input  byte_t din,
    output logic  hit
);
    always_comb begin
        hit = (din == MAIN) || (din == ALT);
    end
endmodule

// File: rtl/apm_level.sv
// Next-state logic of one error row (row index >= 1).
// Bit i of nxt is the row state after pattern position i; bit 0 is never active.
module apm_level #(
    parameter int PAT_LEN = 4
) (
    input  logic [PAT_LEN-1:0] hit,      // hit[p]: byte matches position p+1
    input  logic [PAT_LEN-1:0] cur,      // this row, states 0..PAT_LEN-1
    input  logic [PAT_LEN-1:0] prv,      // row above, states 0..PAT_LEN-1
    input  logic [PAT_LEN-1:0] prv_nxt,  // row above, next value after closure
    input  logic [PAT_LEN-2:0] swp,      // swap-pending states of row above
    output logic [PAT_LEN:0]   nxt
);
    logic [PAT_LEN-1:0] t_exact, t_ins, t_sub, t_del, t_swap;

    always_comb begin
        t_exact = cur & hit;
        t_ins   = {1'b0, prv[PAT_LEN-1:1]};   // no insertion into the final state
        t_sub   = prv & ~hit;
        t_del   = prv_nxt;                     // epsilon skip, resolved this cycle
        t_swap  = {swp & hit[PAT_LEN-2:0], 1'b0};
        nxt     = {t_exact | t_ins | t_sub | t_del | t_swap, 1'b0};
    end
endmodule

// File: rtl/apm_lowest.sv
// Finds the lowest active final row.
module apm_lowest #(
    parameter int ROWS = 3,
    parameter int IW   = 2
) (
    input  logic [ROWS-1:0] fin,
    output logic            any,
    output logic [IW-1:0]   idx
);
    always_comb begin
        any = |fin;
        idx = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (fin[r]) idx = IW'(r);
        end
    end
endmodule

// File: rtl/apm_matcher.sv
// Requires PAT_LEN >= 2 and 1 <= MAX_ERR < PAT_LEN.
module apm_matcher
    import apm_pkg::*;
#(
    parameter int                   PAT_LEN  = 4,
    parameter int                   MAX_ERR  = 2,
    parameter logic [8*PAT_LEN-1:0] PAT_MAIN = "ABCD",
    parameter logic [8*PAT_LEN-1:0] PAT_ALT  = "AbCd",
    localparam int                  ERR_W    = $clog2(MAX_ERR + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din_valid,
    input  logic [7:0]       din,
    output logic             match_o,
    output logic [ERR_W-1:0] err_o
);
    typedef struct packed {
        logic [MAX_ERR:0][PAT_LEN:0]     lvl;  // row j, position i
        logic [MAX_ERR-1:0][PAT_LEN-2:0] swp;  // swap half-done from (i, j)
    } nfa_t;

    nfa_t st_d, st_q, init_st;

    logic [PAT_LEN-1:0]              hit;
    logic [MAX_ERR:0][PAT_LEN:0]     lvl_next;
    logic [MAX_ERR-1:0][PAT_LEN-2:0] swp_next;
    logic [MAX_ERR:0]                fin;

    for (genvar p = 0; p < PAT_LEN; p++) begin : g_dec
        apm_class_dec #(
            .MAIN(PAT_MAIN[8*(PAT_LEN-1-p) +: 8]),
            .ALT (PAT_ALT [8*(PAT_LEN-1-p) +: 8])
        ) u_dec (
            .din(din),
            .hit(hit[p])
        );
    end

    for (genvar j = 0; j <= MAX_ERR; j++) begin : g_row
        logic [PAT_LEN:0] nxt;
        if (j == 0) begin : g_top
            // start state stays active: a match may begin on any byte
            assign nxt = {st_q.lvl[0][PAT_LEN-1:0] & hit, 1'b1};
        end else begin : g_err
            apm_level #(.PAT_LEN(PAT_LEN)) u_lvl (
                .hit    (hit),
                .cur    (st_q.lvl[j][PAT_LEN-1:0]),
                .prv    (st_q.lvl[j-1][PAT_LEN-1:0]),
                .prv_nxt(g_row[j-1].nxt[PAT_LEN-1:0]),
                .swp    (st_q.swp[j-1]),
                .nxt    (nxt)
            );
        end
        assign lvl_next[j] = nxt;
        assign fin[j]      = st_q.lvl[j][PAT_LEN];
        if (j < MAX_ERR) begin : g_swp
            // state i of row j sees the byte of position i+2 first
            assign swp_next[j] = st_q.lvl[j][PAT_LEN-2:0] & hit[PAT_LEN-1:1];
        end
    end

    always_comb begin
        init_st = '0;
        for (int j = 0; j <= MAX_ERR; j++) begin
            init_st.lvl[j][j] = 1'b1;  // start state and its skip closure
        end
        st_d = st_q;
        if (rst) begin
            st_d = init_st;
        end else if (din_valid) begin
            st_d.lvl = lvl_next;
            st_d.swp = swp_next;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    apm_lowest #(.ROWS(MAX_ERR + 1), .IW(ERR_W)) u_low (
        .fin(fin),
        .any(match_o),
        .idx(err_o)
    );

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !din_valid |=> ($stable(match_o) && $stable(err_o))); // R8
    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (err_o <= ERR_W'(MAX_ERR))); // R7
    AST_NO_MATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        !match_o |-> (err_o == '0)); // R7
    AST_MATCH_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(match_o) |-> $past(din_valid)); // R10
endmodule

// File: tb/apm_matcher_tb.sv
`timescale 1ns/1ps
module apm_matcher_tb_top;
    localparam int             M  = 4;
    localparam int             K  = 2;
    localparam logic [8*M-1:0] PM = "ABCD";
    localparam logic [8*M-1:0] PA = "AbCd";

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din_valid = 1'b0;
    logic [7:0] din = 8'h00;
    logic       match_o;
    logic [1:0] err_o;

    always #4 clk = ~clk;

    apm_matcher #(.PAT_LEN(M), .MAX_ERR(K), .PAT_MAIN(PM), .PAT_ALT(PA)) dut_i (
        .clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
        .match_o(match_o), .err_o(err_o)
    );

    typedef struct {
        bit    m;
        int    e;
        string tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         failures = 0;
    bit         done = 0;
    int         dp1[M+1];
    int         dp2[M+1];
    logic [7:0] prevb;
    bit         have_prev;

    function automatic bit in_cls(int pos, logic [7:0] b);
        return (b == PM[8*(M-pos) +: 8]) || (b == PA[8*(M-pos) +: 8]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i <= M; i++) begin
            dp1[i] = i;
            dp2[i] = i;
        end
        have_prev = 0;
    endtask

    // edit distance of the pattern against the best substring ending here
    task automatic model_byte(logic [7:0] b);
        int dn[M+1];
        dn[0] = 0;
        for (int i = 1; i <= M; i++) begin
            int best;
            best = dp1[i-1] + (in_cls(i, b) ? 0 : 1);
            if (i < M && dp1[i] + 1 < best) best = dp1[i] + 1;
            if (dn[i-1] + 1 < best) best = dn[i-1] + 1;
            if (i >= 2 && have_prev && in_cls(i-1, b) && in_cls(i, prevb)
                && dp2[i-2] + 1 < best) best = dp2[i-2] + 1;
            dn[i] = best;
        end
        dp2 = dp1;
        dp1 = dn;
        prevb = b;
        have_prev = 1;
    endtask

    task automatic push(string tag);
        exp_t x;
        x.m = (dp1[M] <= K);
        x.e = x.m ? dp1[M] : 0;
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic send_byte(logic [7:0] b, string tag);
        @(negedge clk);
        rst = 1'b0;
        din_valid = 1'b1;
        din = b;
        model_byte(b);
        push(tag);
    endtask

    task automatic idle(logic [7:0] b, string tag);
        @(negedge clk);
        rst = 1'b0;
        din_valid = 1'b0;
        din = b;
        push(tag);
    endtask

    task automatic send_str(string s, string tag);
        for (int i = 0; i < s.len(); i++) send_byte(s[i], tag);
    endtask

    task automatic pulse_reset(string tag);
        @(negedge clk);
        rst = 1'b1;
        din_valid = 1'b1;
        din = "A";
        model_reset();
        push(tag);
    endtask

    task automatic flush();
        send_str("######", "R7");
    endtask

    // monitor: one expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() != 0) begin
                exp_t x;
                #1;
                x = q.pop_front();
                checks++;
                if (match_o !== x.m || int'(err_o) != x.e) begin
                    failures++;
                    $display("FAIL %s: match=%0d err=%0d expected match=%0d err=%0d",
                             x.tag, match_o, err_o, x.m, x.e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog: cycles=100000 expected completion earlier");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        pulse_reset("R9");              // reset state
        idle("A", "R9");
        send_str("ABCD", "R1");         // exact
        flush();
        send_str("xyABCD", "R10");      // starts mid-stream
        flush();
        send_str("AbCd", "R2");         // both alternates
        flush();
        send_str("Abcd", "R2");         // c is not an alternate
        flush();
        send_str("AXCD", "R3");
        flush();
        send_str("ABZCD", "R4");
        send_str("EF", "R4");           // trailing bytes do not extend
        flush();
        send_str("ABD", "R5");
        flush();
        send_str("BCD", "R5");          // first byte missing
        flush();
        send_str("BACD", "R6");
        flush();
        send_str("ABDC", "R6");
        flush();
        send_str("ACBD", "R6");
        flush();
        send_str("AXYD", "R7");         // two edits
        flush();
        send_str("XYZD", "R7");         // three edits, beyond budget
        flush();
        send_str("AB", "R8");
        idle("C", "R8");                // ignored bytes
        idle("C", "R8");
        idle("D", "R8");
        send_str("CD", "R8");
        idle("Q", "R8");                // match holds
        idle("Q", "R8");
        flush();
        send_str("ABC", "R9");
        pulse_reset("R9");
        send_str("D", "R9");            // earlier bytes forgotten
        send_str("ABCDABDCAbXd", "R7");
        flush();
        @(negedge clk);
        din_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule